// File: doc/BRIEF.md
# Register rename map unit

This block turns the architectural register names of one micro-op per cycle into physical register tags. It keeps a map table with one physical tag for each architectural register and a first-in first-out free list of physical tags not in use. Each micro-op brings up to three source names and up to two destination names, and each has its own valid bit. The condition flags count as one more architectural register, at index 49, so a micro-op that reads or writes the flags names that index like any other register.

For each valid source the block returns the tag that the map table held before this micro-op. For each valid destination it returns a fresh tag from the head of the free list. It also returns the tag that the destination was mapped to until now. That previous tag travels with the micro-op and comes back through the release port when the micro-op commits, and the block appends it to the tail of the free list. If the release port is driven right after renaming, the same rename sequence results, because the list is strictly FIFO. If the free list holds fewer tags than the micro-op needs, the block raises a stall and renames nothing.

Top module: `reg_rename_unit`

## Requirements
- R1: Each valid source tag equals the map table entry as it stood before the current micro-op's destinations update it. A source of the same micro-op that names one of its destinations still gets the older tag.
- R2: For each valid destination, the previous-tag output equals the map entry before the update and the new-tag output is taken from the free list. From the next cycle on, the map entry holds the new tag.
- R3: Tags leave the free list in the order they entered it. Tags released in one cycle enter slot 0 first, then slot 1. When both destinations are valid, slot 0 takes the head tag and slot 1 takes the tag behind it.
- R4: After reset, architectural register i maps to physical tag i. The free list holds tags NUM_ARCH to NUM_PHYS-1 in ascending order, so the first tag allocated is 50 under the default parameters.
- R5: Architectural index 49, the condition flags, is renamed, read and released exactly like any other index.
- R6: When in_valid is high and the free count before this cycle's releases is smaller than the number of valid destinations, stall is high and out_valid is low. The map table and the free list head stay unchanged, while releases in that cycle still take effect.
- R7: When both destinations name the same architectural register, slot 1's previous tag is slot 0's new tag, and the map entry ends holding slot 1's new tag.
- R8: A source or destination slot whose valid bit is clear uses no tag and reads as zero on its outputs. A micro-op with only destination slot 1 valid takes the head tag. All tag outputs are zero when out_valid is low.
- R9: The rename outputs are combinational in the same cycle as the inputs. A tag released in a cycle can be allocated from the next cycle on, but not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A micro-op is presented for renaming |
| src_vld | input | 3 | Valid bit per source slot |
| src_arch | input | 18 | Source architectural indices, slot k in bits [6k+5:6k] |
| dst_vld | input | 2 | Valid bit per destination slot |
| dst_arch | input | 12 | Destination architectural indices, slot k in bits [6k+5:6k] |
| rel_vld | input | 2 | Valid bit per release slot (commit port) |
| rel_tag | input | 12 | Physical tags returned to the free list, slot k in bits [6k+5:6k] |
| out_valid | output | 1 | The micro-op was renamed this cycle |
| stall | output | 1 | Not enough free tags; nothing renamed |
| src_phys | output | 18 | Physical source tags |
| dst_phys | output | 12 | Newly allocated destination tags |
| dst_old | output | 12 | Previous mappings to release at commit |

## Verification
All rename results, the stall and out_valid are due in the same cycle the micro-op is presented, with no register in the path. The map and free-list updates become visible to a micro-op presented one clock later. The bench drives each micro-op on a falling edge and samples the outputs one nanosecond later, well before the next rising edge. It advances its arithmetic model of the map table and the tag queue only after that sample, so each expected value reflects the state that the previous rising edge created. Releases made in a cycle are added to the model after that cycle's allocation, so the model follows the one-cycle delay that R9 describes.

// File: rtl/rn_pkg.sv
// Shared slot counts for the rename unit.
package rn_pkg;
    localparam int SRC_SLOTS = 3;
    localparam int DST_SLOTS = 2;
    localparam int RD_PORTS  = SRC_SLOTS + DST_SLOTS;
endpackage

// File: rtl/rn_map_table.sv
// Map table: one physical tag per architectural register.
// Assumes: reads are combinational; writes land at the clock edge; when
// both write slots hit one entry, slot DST_SLOTS-1 wins.
module rn_map_table
    import rn_pkg::*;
#(
    parameter int NUM_ARCH = 50,
    parameter int NUM_PHYS = 64,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [RD_PORTS*AW-1:0]  rd_arch,
    output logic [RD_PORTS*PW-1:0]  rd_phys,
    input  logic [DST_SLOTS-1:0]    wr_en,
    input  logic [DST_SLOTS*AW-1:0] wr_arch,
    input  logic [DST_SLOTS*PW-1:0] wr_phys
);
    logic [PW-1:0] map_q [NUM_ARCH];

    // Reset to the identity mapping, then apply writes in slot order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_ARCH; e++) map_q[e] <= PW'(e);
        end else begin
            for (int e = 0; e < NUM_ARCH; e++) begin
                for (int w = 0; w < DST_SLOTS; w++) begin
                    if (wr_en[w] && wr_arch[w*AW +: AW] == AW'(e))
                        map_q[e] <= wr_phys[w*PW +: PW];
                end
            end
        end
    end

    // Combinational read ports; out-of-range indices read zero.
    always_comb begin
        for (int r = 0; r < RD_PORTS; r++) begin
            if (int'(rd_arch[r*AW +: AW]) < NUM_ARCH)
                rd_phys[r*PW +: PW] = map_q[rd_arch[r*AW +: AW]];
            else
                rd_phys[r*PW +: PW] = '0;
        end
    end

    // Record last cycle's writes for the checks below.
    logic [DST_SLOTS-1:0]    chk_en_q;
    logic [DST_SLOTS*AW-1:0] chk_arch_q;
    logic [DST_SLOTS*PW-1:0] chk_phys_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_en_q   <= '0;
            chk_arch_q <= '0;
            chk_phys_q <= '0;
        end else begin
            chk_en_q   <= wr_en;
            chk_arch_q <= wr_arch;
            chk_phys_q <= wr_phys;
        end
    end

    // R2
    map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en_q[0] && !(chk_en_q[1] && chk_arch_q[AW +: AW] == chk_arch_q[0 +: AW]))
        |-> map_q[chk_arch_q[0 +: AW]] == chk_phys_q[0 +: PW]);

    // R7
    map_last_slot_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en_q[1] |-> map_q[chk_arch_q[AW +: AW]] == chk_phys_q[PW +: PW]);
endmodule

// File: rtl/rn_free_list.sv
// Free list: circular FIFO of physical tags, up to two pops and two pushes
// per cycle. Assumes NUM_PHYS is a power of two, so pointers wrap freely.
// Pops use the count before this cycle's pushes.
module rn_free_list #(
    parameter int NUM_ARCH = 50,
    parameter int NUM_PHYS = 64,
    localparam int PW    = $clog2(NUM_PHYS),
    localparam int CW    = $clog2(NUM_PHYS + 1),
    localparam int NFREE = NUM_PHYS - NUM_ARCH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    pop_cnt,
    output logic [PW-1:0] head_tag0,
    output logic [PW-1:0] head_tag1,
    input  logic [1:0]    push_vld,
    input  logic [2*PW-1:0] push_tag,
    output logic [CW-1:0] free_cnt
);
    logic [PW-1:0] fifo_q [NUM_PHYS];
    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] cnt_q;
    logic [1:0]    npush;

    // Number of tags returned this cycle.
    assign npush = {1'b0, push_vld[0]} + {1'b0, push_vld[1]};

    // Fill with the spare tags in ascending order; then pop and push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++)
                fifo_q[i] <= (i < NFREE) ? PW'(NUM_ARCH + i) : '0;
            head_q <= '0;
            tail_q <= PW'(NFREE);
            cnt_q  <= CW'(NFREE);
        end else begin
            if (push_vld[0]) fifo_q[tail_q] <= push_tag[0 +: PW];
            if (push_vld[1]) fifo_q[tail_q + PW'(push_vld[0])] <= push_tag[PW +: PW];
            tail_q <= tail_q + PW'(npush);
            head_q <= head_q + PW'(pop_cnt);
            cnt_q  <= cnt_q + CW'(npush) - CW'(pop_cnt);
        end
    end

    // Expose the two oldest tags and the occupancy.
    assign head_tag0 = fifo_q[head_q];
    assign head_tag1 = fifo_q[head_q + PW'(1)];
    assign free_cnt  = cnt_q;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt_q) + int'(npush)) <= NUM_PHYS);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_cnt) <= cnt_q);
endmodule

// File: rtl/reg_rename_unit.sv
// Rename unit top: maps three sources and two destinations of one micro-op
// per cycle to physical tags. Outputs are combinational; state updates at
// the clock edge. Index 49 (condition flags) needs no special handling.
module reg_rename_unit
    import rn_pkg::*;
#(
    parameter int NUM_ARCH = 50,
    parameter int NUM_PHYS = 64,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int PW = $clog2(NUM_PHYS),
    localparam int CW = $clog2(NUM_PHYS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [SRC_SLOTS-1:0]    src_vld,
    input  logic [SRC_SLOTS*AW-1:0] src_arch,
    input  logic [DST_SLOTS-1:0]    dst_vld,
    input  logic [DST_SLOTS*AW-1:0] dst_arch,
    input  logic [DST_SLOTS-1:0]    rel_vld,
    input  logic [DST_SLOTS*PW-1:0] rel_tag,
    output logic                    out_valid,
    output logic                    stall,
    output logic [SRC_SLOTS*PW-1:0] src_phys,
    output logic [DST_SLOTS*PW-1:0] dst_phys,
    output logic [DST_SLOTS*PW-1:0] dst_old
);
    logic [1:0]             need;
    logic                   fire;
    logic [CW-1:0]          free_cnt;
    logic [PW-1:0]          head0, head1;
    logic [RD_PORTS*PW-1:0] map_rd;
    logic [PW-1:0]          new0, new1, old0, old1;

    // Tags this micro-op needs and whether the list can supply them.
    assign need  = {1'b0, dst_vld[0]} + {1'b0, dst_vld[1]};
    assign stall = in_valid && (CW'(need) > free_cnt);
    assign fire  = in_valid && !stall;
    assign out_valid = fire;

    rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_arch ({dst_arch, src_arch}),
        .rd_phys (map_rd),
        .wr_en   (fire ? dst_vld : '0),
        .wr_arch (dst_arch),
        .wr_phys ({new1, new0})
    );

    rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_cnt   (fire ? need : 2'd0),
        .head_tag0 (head0),
        .head_tag1 (head1),
        .push_vld  (rel_vld),
        .push_tag  (rel_tag),
        .free_cnt  (free_cnt)
    );

    // Slot 0 takes the head; slot 1 takes the next one, or the head if alone.
    assign new0 = head0;
    assign new1 = dst_vld[0] ? head1 : head0;

    // Previous mappings; slot 1 sees slot 0's fresh tag when both name one register.
    assign old0 = map_rd[SRC_SLOTS*PW +: PW];
    assign old1 = (dst_vld[0] && dst_arch[AW +: AW] == dst_arch[0 +: AW])
                  ? new0 : map_rd[(SRC_SLOTS+1)*PW +: PW];

    // Gate source tags by slot validity and acceptance.
    for (genvar s = 0; s < SRC_SLOTS; s++) begin : g_src
        assign src_phys[s*PW +: PW] = (fire && src_vld[s]) ? map_rd[s*PW +: PW] : '0;
    end

    // Gate destination tags by slot validity and acceptance.
    assign dst_phys[0 +: PW]  = (fire && dst_vld[0]) ? new0 : '0;
    assign dst_phys[PW +: PW] = (fire && dst_vld[1]) ? new1 : '0;
    assign dst_old[0 +: PW]   = (fire && dst_vld[0]) ? old0 : '0;
    assign dst_old[PW +: PW]  = (fire && dst_vld[1]) ? old1 : '0;

    // R6
    stall_holds_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && rel_vld == '0) |=> $stable(free_cnt));

    // R9
    release_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && rel_vld == 2'b01) |=> free_cnt == $past(free_cnt) + CW'(1));
endmodule

// File: tb/reg_rename_unit_bench.sv
module reg_rename_unit_bench;
    localparam int NA = 50;
    localparam int NP = 64;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0;
    logic [2:0]  src_vld = 0;
    logic [17:0] src_arch = 0;
    logic [1:0]  dst_vld = 0;
    logic [11:0] dst_arch = 0;
    logic [1:0]  rel_vld = 0;
    logic [11:0] rel_tag = 0;
    logic        out_valid, stall;
    logic [17:0] src_phys;
    logic [11:0] dst_phys, dst_old;

    int checks = 0;
    int errors = 0;

    int m_map [NA];
    int m_fq  [NP];
    int m_head, m_tail, m_cnt;

    always #4 clk = ~clk;

    reg_rename_unit u_reg_rename_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_vld(src_vld), .src_arch(src_arch),
        .dst_vld(dst_vld), .dst_arch(dst_arch),
        .rel_vld(rel_vld), .rel_tag(rel_tag),
        .out_valid(out_valid), .stall(stall),
        .src_phys(src_phys), .dst_phys(dst_phys), .dst_old(dst_old)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one micro-op, compare against the model, then advance the model.
    task automatic do_op(input logic [2:0] sv, input int s0, input int s1, input int s2,
                         input logic [1:0] dv, input int d0, input int d1,
                         input logic [1:0] rv, input int r0, input int r1,
                         input string req, output int o0, output int o1);
        int need, n0, n1, p0, p1, e0, e1, e2;
        bit st;
        @(negedge clk);
        in_valid = 1; src_vld = sv; dst_vld = dv; rel_vld = rv;
        src_arch = {6'(s2), 6'(s1), 6'(s0)};
        dst_arch = {6'(d1), 6'(d0)};
        rel_tag  = {6'(r1), 6'(r0)};
        need = int'(dv[0]) + int'(dv[1]);
        st = need > m_cnt;
        e0 = (!st && sv[0]) ? m_map[s0] : 0;
        e1 = (!st && sv[1]) ? m_map[s1] : 0;
        e2 = (!st && sv[2]) ? m_map[s2] : 0;
        n0 = (!st && dv[0]) ? m_fq[m_head] : 0;
        p0 = (!st && dv[0]) ? m_map[d0] : 0;
        n1 = (!st && dv[1]) ? (dv[0] ? m_fq[(m_head + 1) % NP] : m_fq[m_head]) : 0;
        p1 = (!st && dv[1]) ? ((dv[0] && d1 == d0) ? n0 : m_map[d1]) : 0;
        #1;
        chk(stall == st, {req, " R6 stall"}, stall, st);
        chk(out_valid == !st, {req, " R6 out_valid"}, out_valid, !st);
        chk(src_phys == {6'(e2), 6'(e1), 6'(e0)}, {req, " R1 src"}, src_phys, {6'(e2), 6'(e1), 6'(e0)});
        chk(dst_phys == {6'(n1), 6'(n0)}, {req, " R3 new"}, dst_phys, {6'(n1), 6'(n0)});
        chk(dst_old == {6'(p1), 6'(p0)}, {req, " R2 old"}, dst_old, {6'(p1), 6'(p0)});
        if (!st) begin
            if (dv[0]) m_map[d0] = n0;
            if (dv[1]) m_map[d1] = n1;
            m_head = (m_head + need) % NP;
            m_cnt -= need;
        end
        if (rv[0]) begin m_fq[m_tail] = r0; m_tail = (m_tail + 1) % NP; m_cnt++; end
        if (rv[1]) begin m_fq[m_tail] = r1; m_tail = (m_tail + 1) % NP; m_cnt++; end
        o0 = p0; o1 = p1;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int o0, o1, prev0, prev1;
        logic [1:0] prev_dv;
        logic [15:0] lfsr;
        for (int i = 0; i < NA; i++) m_map[i] = i;
        for (int i = 0; i < NP; i++) m_fq[i] = (i < NP - NA) ? NA + i : 0;
        m_head = 0; m_tail = NP - NA; m_cnt = NP - NA;
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R4 reset state, idle
        chk(out_valid == 0 && stall == 0, "R4 idle after reset", {out_valid, stall}, 0);

        // R4 R1: identity map, first tag 50, source sees pre-update mapping
        do_op(3'b001, 5, 0, 0, 2'b01, 5, 0, 2'b00, 0, 0, "R4", o0, o1);
        chk(src_phys[5:0] == 6'd5 && dst_phys[5:0] == 6'd50 && dst_old[5:0] == 6'd5,
            "R4 R1 first rename", {src_phys[5:0], dst_phys[5:0], dst_old[5:0]}, {6'd5, 6'd50, 6'd5});
        // R5 flags index renamed and read back
        do_op(3'b000, 0, 0, 0, 2'b01, 49, 0, 2'b00, 0, 0, "R5 write", o0, o1);
        do_op(3'b100, 0, 0, 49, 2'b00, 0, 0, 2'b00, 0, 0, "R5 read", o0, o1);
        chk(src_phys[17:12] == 6'd51, "R5 flags tag", src_phys[17:12], 51);
        // R7 both destinations name register 7
        do_op(3'b000, 0, 0, 0, 2'b11, 7, 7, 2'b00, 0, 0, "R7", o0, o1);
        chk(dst_old[11:6] == 6'd52 && dst_phys[11:6] == 6'd53, "R7 chained old", dst_old, {6'd52, 6'd7});
        do_op(3'b010, 0, 7, 0, 2'b00, 0, 0, 2'b00, 0, 0, "R7 read", o0, o1);
        // R8 only destination slot 1 valid takes the head
        do_op(3'b000, 0, 0, 0, 2'b10, 0, 3, 2'b00, 0, 0, "R8", o0, o1);
        chk(dst_phys == {6'd54, 6'd0}, "R8 slot1 alone", dst_phys, {6'd54, 6'd0});

        // Sweep: release each micro-op's old tags on the next cycle.
        lfsr = 16'hACE1;
        prev_dv = 2'b00; prev0 = 0; prev1 = 0;
        for (int i = 0; i < 600; i++) begin
            logic [1:0] dv;
            int a0, a1, a2, d0, d1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a0 = lfsr[0] ? 49 : int'(lfsr[7:2]) % NA;
            a1 = int'(lfsr[12:7]) % NA;
            a2 = lfsr[15] ? 49 : int'(lfsr[10:5]) % NA;
            d0 = int'(lfsr[5:1]) % NA;
            d1 = lfsr[9] ? d0 : (lfsr[11] ? 49 : int'(lfsr[14:9]) % NA);
            dv = lfsr[4:3];
            do_op(lfsr[15:13], a0, a1, a2, dv, d0, d1, prev_dv, prev0, prev1,
                  "R1 R2 R3 R5 R7 R8 sweep", o0, o1);
            prev_dv = dv; prev0 = o0; prev1 = o1;
        end
        do_op(3'b000, 0, 0, 0, 2'b00, 0, 0, prev_dv, prev0, prev1, "R3 flush", o0, o1);

        // R6: drain the list with no releases, then expect stalls.
        while (m_cnt > 0) do_op(3'b000, 0, 0, 0, 2'b01, 20, 0, 2'b00, 0, 0, "R6 drain", o0, o1);
        prev0 = m_map[20];
        do_op(3'b000, 0, 0, 0, 2'b01, 20, 0, 2'b00, 0, 0, "R6 empty", o0, o1);
        chk(stall == 1, "R6 stall on empty", stall, 1);
        do_op(3'b001, 20, 0, 0, 2'b00, 0, 0, 2'b00, 0, 0, "R6 map unchanged", o0, o1);
        chk(src_phys[5:0] == 6'(prev0), "R6 map unchanged", src_phys[5:0], prev0);
        // R9: a tag released while stalled is not usable that cycle
        do_op(3'b000, 0, 0, 0, 2'b01, 21, 0, 2'b01, 21, 0, "R9 same cycle", o0, o1);
        chk(stall == 1, "R9 same-cycle release", stall, 1);
        do_op(3'b000, 0, 0, 0, 2'b11, 22, 23, 2'b00, 0, 0, "R6 two needed", o0, o1);
        chk(stall == 1, "R6 one tag for two", stall, 1);
        do_op(3'b000, 0, 0, 0, 2'b01, 22, 0, 2'b00, 0, 0, "R9 next cycle", o0, o1);
        chk(dst_phys[5:0] == 6'd21 && out_valid == 1, "R9 released tag reused", dst_phys[5:0], 21);

        @(negedge clk);
        in_valid = 0; rel_vld = 0;
        #1;
        chk(out_valid == 0 && dst_phys == 0 && src_phys == 0, "R8 idle outputs zero",
            {out_valid, dst_phys, src_phys}, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule